// File: doc/BRIEF.md
# Ternary-Weight Sign Neuron Array

This block holds an array of `N_NEUR` binary neurons that share one programmable connection matrix. Every neuron owns one row of that matrix. Entry 0 of a row weights the neuron's own external input bit. Entries 1 to `N_NEUR` weight the outputs of neurons 1 to `N_NEUR`, the neuron itself included. Each weight is ternary: it is no connection, a straight wire, or an inverter. A binary value of 0 counts as +1 in the sum and a value of 1 counts as -1. A neuron's next output is 1 exactly when its weighted sum is negative.

Software-free configuration happens through a single write port that takes a row, a column and a 2-bit code. Computation advances only when the `step` strobe is high. On such a cycle every neuron evaluates from the outputs that are currently registered, and then all outputs load together. A feedforward arrangement of M layers therefore needs M steps before a change at the inputs reaches the last layer. Feedback entries let the same array form delay lines, oscillators or recurrent nets.

Top module: `tnn_array`

## Requirements
- R1: Reset sets every output to 0 and every stored weight code to 00. After reset a step yields all-zero outputs, whatever the inputs are.
- R2: Weight codes are 2'b00 = no connection, 2'b01 = +1 (wire), 2'b11 = -1 (inverter). The reserved code 2'b10 behaves exactly like 2'b00.
- R3: The term for a source bit is +w when the bit is 0 and -w when the bit is 1. Source 0 is `x_in[i-1]` for neuron i, and source j (1..N) is `y_out[j-1]`. `y_out[i-1]` becomes 1 only if the sum of the terms is negative, so a zero sum gives 0.
- R4: On a cycle with `step` high, all neurons evaluate from the outputs registered before that edge. They update together on the same edge, so a chain of k neurons moves a value by one position per step.
- R5: While `step` is low, `y_out` does not change, even if `x_in` changes.
- R6: An accepted write is stored on the clock edge. A step in the same cycle as a write still uses the weight held before that write.
- R7: A write with row 0, row > `N_NEUR` or column > `N_NEUR` changes no weight.
- R8: In the XOR configuration, neurons 1 and 2 have input weight +1. Neuron 3 has +1 from neuron 1 and -1 from neuron 2. Neuron 4 has -1 from neuron 1 and +1 from neuron 2. Neuron 5 has input weight -1 with its input held at 0, and +1 from neurons 3 and 4. With this configuration, neuron 5 outputs `x_in[0] ^ x_in[1]` after three steps.
- R9: A neuron whose only non-zero weight is +1 on its input reproduces that input one step later.
- R10: A neuron whose only non-zero weight is -1 on its own output toggles on every step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| x_in | input | N_NEUR | External input bit for each neuron (bit i-1 feeds neuron i) |
| wr_en | input | 1 | Weight write strobe |
| wr_row | input | $clog2(N_NEUR+1) | Target neuron, 1..N_NEUR |
| wr_col | input | $clog2(N_NEUR+1) | Source column: 0 = input, j = output of neuron j |
| wr_code | input | 2 | Ternary weight code |
| step | input | 1 | Advance the network one step on this edge |
| y_out | output | N_NEUR | Registered neuron outputs (bit i-1 is neuron i) |

## Verification
The tests are built to separate specific mistakes, each with its own configuration.

- **Wire and inverter codes:** single-weight neurons fed with input 0 and input 1 show whether these two codes carry the correct sign.
- **Reserved code:** a neuron holding the reserved code is given an input that would make it fire if it were decoded as a wire.
- **Zero sum:** a neuron with two opposing terms separates "zero sum gives 0" from an off-by-one threshold.
- **Two-neuron chain:** this exposes any update that reads outputs already refreshed in the same step.
- **Self-inverting neuron:** this checks feedback timing.
- **Write and step together:** this checks that the step uses the old weight.
- **Out-of-range writes:** these check that no aliased cell is written.
- **XOR configuration:** all four input pairs are run through it, so the full three-layer path is checked against the parity of the inputs.

// File: rtl/tnn_pkg.sv
package tnn_pkg;

  typedef logic [1:0] wcode_t;

  localparam wcode_t W_NONE = 2'b00;
  localparam wcode_t W_PASS = 2'b01;
  localparam wcode_t W_RSVD = 2'b10;
  localparam wcode_t W_INV  = 2'b11;

  // Signed value of a binary source: 0 counts as +1, 1 counts as -1.
  function automatic logic signed [1:0] bit_value(input logic b);
    return b ? -2'sd1 : 2'sd1;
  endfunction

  // Contribution of one weighted source to a neuron sum.
  function automatic logic signed [1:0] tern_term(input wcode_t c, input logic b);
    logic signed [1:0] v;
    v = bit_value(b);
    case (c)
      W_PASS:  return v;
      W_INV:   return -v;
      default: return 2'sd0;
    endcase
  endfunction

  // True when a code connects its source (wire or inverter).
  function automatic logic code_live(input wcode_t c);
    return (c == W_PASS) || (c == W_INV);
  endfunction

endpackage

// File: rtl/tnn_weight_bank.sv
module tnn_weight_bank
  import tnn_pkg::*;
#(
  parameter int N_NEUR = 8,
  parameter int IDX_W  = $clog2(N_NEUR + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_row,
  input  logic [IDX_W-1:0]              wr_col,
  input  wcode_t                        wr_code,
  output logic                          wr_hit,
  output logic [N_NEUR*(N_NEUR+1)*2-1:0] w_flat
);

  localparam int N_COL = N_NEUR + 1;
  localparam logic [IDX_W-1:0] ROW_LO = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_HI = IDX_W'(N_NEUR);

  logic row_ok;
  logic col_ok;

  assign row_ok = (wr_row >= ROW_LO) && (wr_row <= IDX_HI);
  assign col_ok = (wr_col <= IDX_HI);
  assign wr_hit = wr_en && row_ok && col_ok;

  for (genvar r = 0; r < N_NEUR; r++) begin : g_row
    for (genvar c = 0; c < N_COL; c++) begin : g_col
      wcode_t cell_q;
      logic   sel;

      assign sel = wr_hit && (wr_row == IDX_W'(r + 1)) && (wr_col == IDX_W'(c));

      always_ff @(posedge clk) begin
        if (rst) begin
          cell_q <= W_NONE;
        end else if (sel) begin
          cell_q <= wr_code;
        end
      end

      assign w_flat[(r*N_COL + c)*2 +: 2] = cell_q;
    end
  end

endmodule

// File: rtl/tnn_neuron_sum.sv
module tnn_neuron_sum
  import tnn_pkg::*;
#(
  parameter int N_NEUR = 8,
  parameter int SUM_W  = $clog2(N_NEUR + 2) + 1
) (
  input  logic [(N_NEUR+1)*2-1:0]  w_row,
  input  logic                     x_bit,
  input  logic [N_NEUR-1:0]        y_vec,
  output logic signed [SUM_W-1:0]  sum_o,
  output logic                     neg_o
);

  localparam int N_SRC = N_NEUR + 1;

  logic [N_SRC-1:0]  src;
  logic signed [1:0] term [N_SRC];

  assign src = {y_vec, x_bit};

  for (genvar k = 0; k < N_SRC; k++) begin : g_term
    assign term[k] = tern_term(wcode_t'(w_row[k*2 +: 2]), src[k]);
  end

  always_comb begin
    sum_o = '0;
    for (int k = 0; k < N_SRC; k++) begin
      sum_o = sum_o + SUM_W'(term[k]);
    end
  end

  assign neg_o = sum_o[SUM_W-1];

endmodule

// File: rtl/tnn_state_reg.sv
module tnn_state_reg #(
  parameter int N_NEUR = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic [N_NEUR-1:0] y_next,
  output logic [N_NEUR-1:0] y_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      y_q <= '0;
    end else if (step) begin
      y_q <= y_next;
    end
  end

endmodule

// File: rtl/tnn_array.sv
module tnn_array
  import tnn_pkg::*;
#(
  parameter int N_NEUR = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_NEUR-1:0]             x_in,
  input  logic                          wr_en,
  input  logic [$clog2(N_NEUR+1)-1:0]   wr_row,
  input  logic [$clog2(N_NEUR+1)-1:0]   wr_col,
  input  logic [1:0]                    wr_code,
  input  logic                          step,
  output logic [N_NEUR-1:0]             y_out
);

  localparam int IDX_W  = $clog2(N_NEUR + 1);
  localparam int N_COL  = N_NEUR + 1;
  localparam int ROW_BW = N_COL * 2;
  localparam int SUM_W  = $clog2(N_NEUR + 2) + 1;

  logic [N_NEUR*ROW_BW-1:0] w_flat;
  logic                     wr_hit;
  logic [N_NEUR-1:0]        y_next;

  tnn_weight_bank #(
    .N_NEUR (N_NEUR),
    .IDX_W  (IDX_W)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_row  (wr_row),
    .wr_col  (wr_col),
    .wr_code (wcode_t'(wr_code)),
    .wr_hit  (wr_hit),
    .w_flat  (w_flat)
  );

  for (genvar i = 0; i < N_NEUR; i++) begin : g_neu
    logic signed [SUM_W-1:0] sum_i;

    tnn_neuron_sum #(
      .N_NEUR (N_NEUR),
      .SUM_W  (SUM_W)
    ) u_sum (
      .w_row (w_flat[i*ROW_BW +: ROW_BW]),
      .x_bit (x_in[i]),
      .y_vec (y_out),
      .sum_o (sum_i),
      .neg_o (y_next[i])
    );
  end

  tnn_state_reg #(
    .N_NEUR (N_NEUR)
  ) u_state (
    .clk    (clk),
    .rst    (rst),
    .step   (step),
    .y_next (y_next),
    .y_q    (y_out)
  );

endmodule

// File: rtl/tnn_array_chk.sv
module tnn_array_chk #(
  parameter int N_NEUR = 8
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           step,
  input logic                           wr_en,
  input logic [$clog2(N_NEUR+1)-1:0]    wr_row,
  input logic [$clog2(N_NEUR+1)-1:0]    wr_col,
  input logic [N_NEUR-1:0]              y_out,
  input logic [N_NEUR-1:0]              y_next,
  input logic [N_NEUR*(N_NEUR+1)*2-1:0] w_flat
);

  localparam int IDX_W = $clog2(N_NEUR + 1);
  localparam int N_COL = N_NEUR + 1;

  logic bad_addr;
  assign bad_addr = (wr_row == '0) || (wr_row > IDX_W'(N_NEUR)) || (wr_col > IDX_W'(N_NEUR));

  // A row with no wire and no inverter (reserved code included) has a zero sum.
  logic [N_NEUR-1:0] row_live;
  for (genvar r = 0; r < N_NEUR; r++) begin : g_live
    logic [N_COL-1:0] lsb;
    for (genvar c = 0; c < N_COL; c++) begin : g_c
      assign lsb[c] = w_flat[(r*N_COL + c)*2];
    end
    assign row_live[r] = |lsb;

    p_dead_row_r2: assert property (@(posedge clk) disable iff (rst)
      !row_live[r] |-> !y_next[r]);
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (y_out == '0) && (w_flat == '0));

  p_step_load_r4: assert property (@(posedge clk) disable iff (rst)
    step |=> (y_out == $past(y_next)));

  p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(y_out));

  p_no_write_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(w_flat));

  p_bad_addr_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bad_addr) |=> $stable(w_flat));

endmodule

bind tnn_array tnn_array_chk #(.N_NEUR(N_NEUR)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .step   (step),
  .wr_en  (wr_en),
  .wr_row (wr_row),
  .wr_col (wr_col),
  .y_out  (y_out),
  .y_next (y_next),
  .w_flat (w_flat)
);

// File: tb/tnn_array_test.sv
module tnn_array_test;

  localparam int  N  = 8;
  localparam int  IW = $clog2(N + 1);
  localparam time CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  x_in;
  logic          wr_en;
  logic [IW-1:0] wr_row;
  logic [IW-1:0] wr_col;
  logic [1:0]    wr_code;
  logic          step;
  logic [N-1:0]  y_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  int           wm [N][N+1];
  logic [N-1:0] ym;

  tnn_array #(.N_NEUR(N)) uut (
    .clk(clk), .rst(rst), .x_in(x_in), .wr_en(wr_en), .wr_row(wr_row),
    .wr_col(wr_col), .wr_code(wr_code), .step(step), .y_out(y_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int code_to_int(input logic [1:0] c);
    if (c == 2'b01) return 1;
    if (c == 2'b11) return -1;
    return 0;
  endfunction

  function automatic void model_step();
    logic [N-1:0] nv;
    for (int i = 0; i < N; i++) begin
      int s;
      s = x_in[i] ? -wm[i][0] : wm[i][0];
      for (int j = 0; j < N; j++) s += ym[j] ? -wm[i][j+1] : wm[i][j+1];
      nv[i] = (s < 0);
    end
    ym = nv;
  endfunction

  function automatic void model_write(input int row, input int col, input logic [1:0] c);
    if (row >= 1 && row <= N && col >= 0 && col <= N) wm[row-1][col] = code_to_int(c);
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: y_out actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic apply_reset();
    rst = 1'b1; x_in = '0; wr_en = 1'b0; wr_row = '0; wr_col = '0; wr_code = 2'b00; step = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < N; i++) for (int j = 0; j <= N; j++) wm[i][j] = 0;
    ym = '0;
  endtask

  task automatic put_w(input int row, input int col, input logic [1:0] c);
    @(negedge clk);
    wr_en = 1'b1; wr_row = IW'(row); wr_col = IW'(col); wr_code = c;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(row, col, c);
  endtask

  task automatic do_step();
    @(negedge clk);
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
    model_step();
  endtask

  task automatic t_reset();
    apply_reset();
    check("R1 reset outputs", y_out, '0);
    x_in = '1;
    do_step();
    check("R1 cleared weights give zero", y_out, '0);
  endtask

  task automatic t_delay_hold();
    apply_reset();
    put_w(1, 0, 2'b01);
    x_in = 8'h01;
    do_step();
    check("R9 delay passes 1", y_out, 8'h01);
    x_in = 8'h00;
    repeat (3) @(negedge clk);
    check("R5 no step holds", y_out, 8'h01);
    do_step();
    check("R9 delay passes 0", y_out, 8'h00);
  endtask

  task automatic t_codes();
    apply_reset();
    put_w(2, 0, 2'b11);
    put_w(3, 0, 2'b10);
    put_w(4, 0, 2'b01);
    x_in = 8'b0000_1100;
    do_step();
    // neuron2: inverter of 0 -> 1; neuron3: reserved on 1 -> 0; neuron4: wire of 1 -> 1
    check("R2 code decode", y_out, 8'b0000_1010);
    check("R2 model agreement", y_out, ym);
  endtask

  task automatic t_tie();
    apply_reset();
    put_w(4, 0, 2'b01);
    put_w(4, 1, 2'b01);
    x_in = 8'b0000_1000;
    do_step();
    check("R3 zero sum gives 0", y_out, 8'h00);
    put_w(4, 2, 2'b11);
    do_step();
    check("R3 negative sum gives 1", y_out, 8'b0000_1000);
  endtask

  task automatic t_sync();
    apply_reset();
    put_w(1, 0, 2'b01);
    put_w(2, 1, 2'b01);
    x_in = 8'h01;
    do_step();
    check("R4 chain first step", y_out, 8'b0000_0001);
    do_step();
    check("R4 chain second step", y_out, 8'b0000_0011);
  endtask

  task automatic t_write_step();
    apply_reset();
    put_w(1, 0, 2'b01);
    x_in = 8'h01;
    @(negedge clk);
    wr_en = 1'b1; wr_row = IW'(1); wr_col = IW'(0); wr_code = 2'b11; step = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; step = 1'b0;
    model_step();
    model_write(1, 0, 2'b11);
    check("R6 step uses old weight", y_out, 8'h01);
    do_step();
    check("R6 new weight after write", y_out, 8'h00);
  endtask

  task automatic t_range();
    apply_reset();
    put_w(0, 0, 2'b11);
    put_w(N + 1, 0, 2'b11);
    put_w(1, N + 1, 2'b11);
    put_w(15, 15, 2'b11);
    x_in = '0;
    do_step();
    check("R7 bad addresses ignored", y_out, 8'h00);
    check("R7 model agreement", y_out, ym);
  endtask

  task automatic t_osc();
    apply_reset();
    put_w(6, 6, 2'b11);
    do_step();
    check("R10 toggle to 1", y_out, 8'b0010_0000);
    do_step();
    check("R10 toggle to 0", y_out, 8'b0000_0000);
  endtask

  task automatic t_xor();
    apply_reset();
    put_w(1, 0, 2'b01); put_w(2, 0, 2'b01);
    put_w(3, 1, 2'b01); put_w(3, 2, 2'b11);
    put_w(4, 1, 2'b11); put_w(4, 2, 2'b01);
    put_w(5, 0, 2'b11); put_w(5, 3, 2'b01); put_w(5, 4, 2'b01);
    for (int p = 0; p < 4; p++) begin
      logic a, b;
      a = p[0];
      b = p[1];
      x_in = {6'b0, b, a};
      repeat (3) do_step();
      check("R8 xor output", {7'b0, y_out[4]}, {7'b0, a ^ b});
      check("R8 model agreement", y_out, ym);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_delay_hold();
    t_codes();
    t_tie();
    t_sync();
    t_write_step();
    t_range();
    t_osc();
    t_xor();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule